// File: doc/BRIEF.md
# Motion-Adaptive Line Deinterlacer Pixel Core

This core rebuilds one output pixel of a progressive frame from an interlaced source. For every pixel it receives a 3x3 neighbourhood from the current frame and the same neighbourhood from the previous frame. It also receives the two pixels directly above and below in the current field, the pixel at the same position in the field of opposite parity, and the original pixel at the output position. Pixels on lines that the current field already carries go out unchanged. For pixels on missing lines the core measures motion and picks one of two values. In moving areas it interpolates within the field (bob). In still areas it takes the pixel from the other field (weave).

The motion measure is the sum of absolute differences over the nine pixel pairs. A persistence option keeps earlier motion alive: the effective value is never below half the motion stored for that pixel in the previous frame. The effective value goes out on every result, so the surrounding frame store can keep it for the next frame. A small write-only register port sets the motion threshold, a pass-through mode for progressive sources, the persistence enable and the line parity of the first field in a frame. Input and output use ready/valid handshakes, and the pipeline is two registers deep.

Top module: `madi_core`

## Requirements
- R1: A missing-line pixel uses the bob value when the effective motion is strictly greater than the threshold register, and the weave value otherwise. An effective motion equal to the threshold selects weave.
- R2: The bob value is (pix_above + pix_below + 1) >> 1, computed without overflow.
- R3: The weave value is pix_opp, unmodified.
- R4: A pixel on a line the current field carries outputs pix_orig, whatever the motion.
- R5: When mode bit 0 (pass-through) is 1, every pixel outputs pix_orig.
- R6: Mode bit 2 gives the line parity (0 even, 1 odd) of the first field in a frame. The current field has parity (mode bit 2) XOR fld_second. A pixel is on a missing line when row_odd differs from that parity.
- R7: With mode bit 1 (persistence) at 1, the effective motion is the larger of the nine-pair SAD and prev_motion >> 1. With the bit at 0 it is the SAD alone. motion_out carries the effective motion of each result.
- R8: A pixel accepted (in_valid and in_ready high) in cycle n appears with out_valid high in cycle n+2, provided out_ready was high in cycle n+1.
- R9: While out_valid is high and out_ready is low, out_pix and motion_out hold steady and no result is lost or duplicated. in_ready falls only when both stages are full and the output is blocked.
- R10: After reset, out_valid is 0, in_ready is 1, the threshold is THR_RST (32) and all mode bits are 0. An asserted reset clears out_valid at once.
- R11: A write with cfg_sel = 0 loads the threshold from cfg_data. A write with cfg_sel = 1 loads the mode from cfg_data[2:0]. Either write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 threshold, 1 mode |
| cfg_data | input | MW (12) | Write data |
| in_valid | input | 1 | Input pixel set valid |
| in_ready | output | 1 | Core can accept input |
| cur_win | input | TAPS*PW (72) | 3x3 window, current frame |
| prv_win | input | TAPS*PW (72) | 3x3 window, previous frame |
| pix_above | input | PW (8) | Field pixel above the target |
| pix_below | input | PW (8) | Field pixel below the target |
| pix_opp | input | PW (8) | Co-located pixel of opposite-parity field |
| pix_orig | input | PW (8) | Source pixel at the target position |
| fld_second | input | 1 | Current field is the second of its frame |
| row_odd | input | 1 | Target line is odd |
| prev_motion | input | MW (12) | Stored motion for this pixel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_pix | output | PW (8) | Reconstructed pixel |
| motion_out | output | MW (12) | Effective motion, for storage |

## Verification
The assertions check the handshake on every cycle: held outputs under back-pressure, stage advance after acceptance, in_ready falling only on a blocked full pipe, and a bob average that always lies between its two neighbours. The pixel choice depends on values, so only the bench's scenarios can show it. These cover threshold equality, field-parity selection, pass-through, persistence that overrides or loses to the SAD, the reset defaults, and ordering after a long stall.

// File: rtl/madi_pkg.sv
package madi_pkg;

  typedef enum logic {
    REG_THR  = 1'b0,
    REG_MODE = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic first_odd;
    logic bleed_en;
    logic pass_en;
  } mode_t;

endpackage

// File: rtl/madi_motion.sv
module madi_motion #(
  parameter int PW   = 8,
  parameter int TAPS = 9,
  parameter int MW   = PW + $clog2(TAPS)
) (
  input  logic [TAPS*PW-1:0] cur_win,
  input  logic [TAPS*PW-1:0] prv_win,
  input  logic [MW-1:0]      prev_mot,
  input  logic               bleed_en,
  output logic [MW-1:0]      eff_mot
);

  logic [PW-1:0] diff [TAPS];
  logic [MW-1:0] sad;
  logic [MW-1:0] decayed;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic [PW-1:0] a, b;
    assign a = cur_win[i*PW +: PW];
    assign b = prv_win[i*PW +: PW];
    assign diff[i] = (a >= b) ? (a - b) : (b - a);
  end

  always_comb begin
    sad = '0;
    for (int i = 0; i < TAPS; i++) begin
      sad = sad + MW'(diff[i]);
    end
  end

  assign decayed = prev_mot >> 1;
  assign eff_mot = (bleed_en && (decayed > sad)) ? decayed : sad;

endmodule

// File: rtl/madi_bob.sv
module madi_bob #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] up,
  input  logic [PW-1:0] dn,
  output logic [PW-1:0] avg
);

  logic [PW:0] total;

  assign total = {1'b0, up} + {1'b0, dn} + {{PW{1'b0}}, 1'b1};
  assign avg   = total[PW:1];

  always_comb begin
    p_avg_between_r2: assert ((avg >= ((up < dn) ? up : dn)) && (avg <= ((up > dn) ? up : dn)));
  end

endmodule

// File: rtl/madi_core.sv
module madi_core
  import madi_pkg::*;
#(
  parameter int PW      = 8,
  parameter int TAPS    = 9,
  parameter int THR_RST = 32,
  localparam int MW     = PW + $clog2(TAPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [MW-1:0]      cfg_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAPS*PW-1:0] cur_win,
  input  logic [TAPS*PW-1:0] prv_win,
  input  logic [PW-1:0]      pix_above,
  input  logic [PW-1:0]      pix_below,
  input  logic [PW-1:0]      pix_opp,
  input  logic [PW-1:0]      pix_orig,
  input  logic               fld_second,
  input  logic               row_odd,
  input  logic [MW-1:0]      prev_motion,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PW-1:0]      out_pix,
  output logic [MW-1:0]      motion_out
);

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // control registers
  logic [MW-1:0] thr_q, thr_d;
  mode_t         mode_q, mode_d;
  logic          unused_hi;

  assign unused_hi = ^cfg_data[MW-1:3];

  always_comb begin
    thr_d  = thr_q;
    mode_d = mode_q;
    if (cfg_wr) begin
      if (reg_sel_e'(cfg_sel) == REG_THR) thr_d  = cfg_data;
      else                                mode_d = mode_t'(cfg_data[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      thr_q  <= MW'(THR_RST);
      mode_q <= '0;
    end else begin
      thr_q  <= thr_d;
      mode_q <= mode_d;
    end
  end

  // stage 0 combinational work
  logic [MW-1:0] eff_c;
  logic [PW-1:0] bob_c;
  logic          miss_c;

  madi_motion #(.PW(PW), .TAPS(TAPS), .MW(MW)) u_motion (
    .cur_win  (cur_win),
    .prv_win  (prv_win),
    .prev_mot (prev_motion),
    .bleed_en (mode_q.bleed_en),
    .eff_mot  (eff_c)
  );

  madi_bob #(.PW(PW)) u_bob (
    .up  (pix_above),
    .dn  (pix_below),
    .avg (bob_c)
  );

  assign miss_c = (row_odd != (mode_q.first_odd ^ fld_second)) && !mode_q.pass_en;

  // pipeline control
  logic en1, en2;
  logic s1_v, s1_v_d, s2_v, s2_v_d;
  logic          s1_miss;
  logic [MW-1:0] s1_eff;
  logic [PW-1:0] s1_bob, s1_opp, s1_orig;
  logic [PW-1:0] s2_pix, pix_d;
  logic [MW-1:0] s2_mot;

  assign en2    = !s2_v || out_ready;
  assign en1    = !s1_v || en2;
  assign s1_v_d = en1 ? in_valid : s1_v;
  assign s2_v_d = en2 ? s1_v : s2_v;

  always_comb begin
    if (!s1_miss)            pix_d = s1_orig;
    else if (s1_eff > thr_q) pix_d = s1_bob;
    else                     pix_d = s1_opp;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= s1_v_d;
      s2_v <= s2_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en1 && in_valid) begin
      s1_eff  <= eff_c;
      s1_miss <= miss_c;
      s1_bob  <= bob_c;
      s1_opp  <= pix_opp;
      s1_orig <= pix_orig;
    end
    if (en2 && s1_v) begin
      s2_pix <= pix_d;
      s2_mot <= s1_eff;
    end
  end

  assign in_ready   = en1;
  assign out_valid  = s2_v;
  assign out_pix    = s2_pix;
  assign motion_out = s2_mot;

  // checks
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(motion_out)));

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_ready |-> (out_valid && !out_ready && s1_v));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_ready) |=> s1_v);

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (s1_v && (!out_valid || out_ready)) |=> out_valid);

endmodule

// File: tb/madi_core_bench.sv
module madi_core_bench;

  localparam int PW = 8;
  localparam int TAPS = 9;
  localparam int MW = 12;

  typedef struct packed {
    logic [2:0]  mode;
    logic [11:0] thr;
    logic [7:0]  cb, pb, ab, bl, opp, orig;
    logic        f2, ro;
    logic [11:0] prev;
    logic [7:0]  ep;
    logic [11:0] em;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'b000, 12'd32, 8'd100, 8'd100, 8'd10,  8'd20,  8'd77, 8'd5,   1'b0, 1'b1, 12'd0,   8'd77,  12'd0},
    '{3'b000, 12'd32, 8'd110, 8'd100, 8'd10,  8'd21,  8'd77, 8'd5,   1'b0, 1'b1, 12'd0,   8'd16,  12'd90},
    '{3'b000, 12'd32, 8'd104, 8'd100, 8'd200, 8'd201, 8'd55, 8'd5,   1'b0, 1'b1, 12'd0,   8'd201, 12'd36},
    '{3'b000, 12'd36, 8'd104, 8'd100, 8'd200, 8'd201, 8'd55, 8'd5,   1'b0, 1'b1, 12'd0,   8'd55,  12'd36},
    '{3'b000, 12'd32, 8'd110, 8'd100, 8'd10,  8'd21,  8'd77, 8'd123, 1'b0, 1'b0, 12'd0,   8'd123, 12'd90},
    '{3'b001, 12'd32, 8'd110, 8'd100, 8'd10,  8'd21,  8'd77, 8'd99,  1'b0, 1'b1, 12'd0,   8'd99,  12'd90},
    '{3'b100, 12'd32, 8'd100, 8'd100, 8'd10,  8'd20,  8'd66, 8'd44,  1'b0, 1'b1, 12'd0,   8'd44,  12'd0},
    '{3'b100, 12'd32, 8'd100, 8'd100, 8'd10,  8'd20,  8'd66, 8'd44,  1'b1, 1'b1, 12'd0,   8'd66,  12'd0},
    '{3'b010, 12'd32, 8'd100, 8'd100, 8'd0,   8'd255, 8'd9,  8'd5,   1'b0, 1'b1, 12'd100, 8'd128, 12'd50},
    '{3'b010, 12'd32, 8'd105, 8'd100, 8'd1,   8'd2,   8'd9,  8'd5,   1'b0, 1'b1, 12'd80,  8'd2,   12'd45},
    '{3'b000, 12'd32, 8'd100, 8'd100, 8'd1,   8'd2,   8'd9,  8'd5,   1'b0, 1'b1, 12'd200, 8'd9,   12'd0},
    '{3'b010, 12'd32, 8'd100, 8'd100, 8'd1,   8'd2,   8'd12, 8'd5,   1'b0, 1'b1, 12'd65,  8'd12,  12'd32}
  };

  function automatic string tag_of(int i);
    case (i)
      0:       return "R3 weave";
      1, 2:    return "R1/R2 bob";
      3:       return "R1 equal threshold";
      4:       return "R4 existing line";
      5:       return "R5 pass-through";
      6, 7:    return "R6 field parity";
      default: return "R7 persistence";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_sel;
  logic [MW-1:0] cfg_data;
  logic in_valid, in_ready;
  logic [TAPS*PW-1:0] cur_win, prv_win;
  logic [PW-1:0] pix_above, pix_below, pix_opp, pix_orig;
  logic fld_second, row_odd;
  logic [MW-1:0] prev_motion;
  logic out_valid, out_ready;
  logic [PW-1:0] out_pix;
  logic [MW-1:0] motion_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  madi_core u_madi_core (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .cur_win(cur_win), .prv_win(prv_win),
    .pix_above(pix_above), .pix_below(pix_below), .pix_opp(pix_opp), .pix_orig(pix_orig),
    .fld_second(fld_second), .row_odd(row_odd), .prev_motion(prev_motion),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .motion_out(motion_out)
  );

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic cfg_write(logic sel, int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = MW'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic drive(int i);
    cur_win = {TAPS{TBL[i].cb}};
    prv_win = {TAPS{TBL[i].pb}};
    pix_above = TBL[i].ab; pix_below = TBL[i].bl;
    pix_opp = TBL[i].opp;  pix_orig = TBL[i].orig;
    fld_second = TBL[i].f2; row_odd = TBL[i].ro;
    prev_motion = TBL[i].prev;
  endtask

  // present vector i for one cycle with out_ready high, then check
  task automatic run_vec(int i, string tag);
    @(negedge clk);
    drive(i); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 not early"}, int'(out_valid), 0);
    @(negedge clk);
    check({tag, " R8 valid"}, int'(out_valid), 1);
    check({tag, " pixel"}, int'(out_pix), int'(TBL[i].ep));
    check({tag, " R7 motion_out"}, int'(motion_out), int'(TBL[i].em));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_data = '0;
    in_valid = 1'b0; out_ready = 1'b1;
    drive(0);
    do_reset();

    // R10 reset state
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 in_ready after reset", int'(in_ready), 1);
    // R10 default threshold 32 and mode 0: SAD 36 > 32 gives bob 201
    run_vec(2, "R10 default config");

    // table walk, R11 register writes before each vector
    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, int'(TBL[i].thr));
      cfg_write(1'b1, int'(TBL[i].mode));
      run_vec(i, tag_of(i));
    end

    // R9 back-pressure: three results, output blocked
    cfg_write(1'b0, 32);
    cfg_write(1'b1, 0);
    out_ready = 1'b0;
    @(negedge clk); drive(0); in_valid = 1'b1;
    @(negedge clk); drive(1);
    @(negedge clk); drive(2);
    check("R9 in_ready low when full", int'(in_ready), 0);
    check("R9 first result held", int'(out_pix), 77);
    @(negedge clk);
    check("R9 still valid", int'(out_valid), 1);
    check("R9 stable pixel", int'(out_pix), 77);
    check("R9 stable motion", int'(motion_out), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result", int'(out_pix), 16);
    @(negedge clk);
    check("R9 third result", int'(out_pix), 201);
    check("R9 third valid", int'(out_valid), 1);
    @(negedge clk);
    check("R9 no duplicate", int'(out_valid), 0);

    // R10 asynchronous clear while a result is pending
    out_ready = 1'b0;
    @(negedge clk); drive(0); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R10 pending before reset", int'(out_valid), 1);
    rst_n = 1'b0;
    #1;
    check("R10 reset clears out_valid", int'(out_valid), 0);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", int'(out_valid), 0);
    // R11 threshold back to reset value: SAD 36 > 32 bob again
    run_vec(2, "R11 threshold reset");

    finish_run();
  end

endmodule